// File: doc/BRIEF.md
# Fast-Lock Bandwidth Switching Sequencer

This block times the hand-over of a frequency synthesizer's loop from a wide settling bandwidth to its normal, narrow bandwidth. Every load of the main frequency word pulses `load_i`. The sequencer then forces the wide-bandwidth condition: it selects the high charge-pump current code and closes both loop-filter damping switches. Two independent timers then count reference clock cycles. When the current timer expires, the current select drops to the normal code. When the switch timer expires, both switches open together and the loop narrows.

Each timer works from a count that software programs before the frequency load. The counts are captured on the load edge, so each event falls on a chosen whole reference cycle. A done flag rises once both events have happened and stays high until the next load. A busy flag covers the interval from the load to done. A new load during a running sequence restarts both timers from zero.

Top module: `fastlock_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `icp_sel_o` equals the normal code (default 2'b00), both switch outputs are 0 (open), and `busy_o` and `done_o` are 0.
- R2: On the clock edge that samples `load_i` high, the outputs become wide mode: `icp_sel_o` equals the wide code (default 2'b11), `sw1_close_o` = `sw2_close_o` = 1, `busy_o` = 1 and `done_o` = 0.
- R3: Let Ti be the current timeout captured at the load. `icp_sel_o` returns to the normal code at the (Ti+1)-th rising edge after the load edge, and holds the wide code before that edge.
- R4: Let Ts be the switch timeout captured at the load. Both switch outputs fall to 0 on the same edge, the (Ts+1)-th rising edge after the load edge. Before that edge both stay at 1.
- R5: A timeout of zero places its event on the first rising edge after the load edge.
- R6: Both timeout inputs are captured only on the load edge. Changing them while a sequence runs does not move either event.
- R7: A load during a running sequence restarts both timers from zero, using the newly captured timeouts, and returns all outputs to wide mode at once.
- R8: `done_o` rises and `busy_o` falls on the edge max(Ti,Ts)+1 after the load edge. `done_o` then stays high with the outputs in narrow mode until the next load, and `busy_o` and `done_o` are never high together.
- R9: The full 10-bit range works. A timeout of 1023 places its event on edge 1024 after the load.
- R10: Without a load, the block stays idle after reset. No output leaves its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PFD reference clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | One-cycle pulse on each main frequency load |
| icp_tmo_i | input | 10 | Reference cycles before the charge-pump current drops |
| sw_tmo_i | input | 10 | Reference cycles before the filter switches open |
| icp_sel_o | output | 2 | Charge-pump current select (wide or normal code) |
| sw1_close_o | output | 1 | First loop-filter switch enable, 1 = closed |
| sw2_close_o | output | 1 | Second loop-filter switch enable, 1 = closed |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Both events have occurred since the last load |

## Verification
Each event is a single edge of a registered output, so a wrong internal state shows up as an output edge that comes early or late. A counter that misses its compare value, or that is not cleared on a reload, moves the current-select or switch edge off its expected reference cycle. That error is visible on the first cycle it occurs. A missing capture of the timeout shows up only when the inputs change mid-sequence, as an event that follows the new value. An error in the done logic shows up as a flag that rises before the later event, stays low past it, or drops without a load.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;
  localparam int CNT_W     = 10;
  localparam int CP_W      = 2;
  localparam int NUM_EV    = 2;
  localparam int EV_ICP    = 0;
  localparam int EV_SW     = 1;
  localparam logic [CP_W-1:0] CP_WIDE = 2'b11;
  localparam logic [CP_W-1:0] CP_NORM = 2'b00;
endpackage

// File: rtl/fastlock_timer.sv
module fastlock_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] tmo_i,
  output logic             hit_o,
  output logic             spent_o
);
  logic [CNT_W-1:0] tmo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign hit_o = run_q && (cnt_q == tmo_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      spent_o <= 1'b0;
    end else if (start_i) begin
      tmo_q   <= tmo_i;
      cnt_q   <= '0;
      run_q   <= 1'b1;
      spent_o <= 1'b0;
    end else if (run_q) begin
      if (hit_o) begin
        run_q   <= 1'b0;
        spent_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q <= tmo_q)); // R9
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (run_q && cnt_q == '0 && !spent_o)); // R7
  AST_TMO_HELD: assert property (@(posedge clk) disable iff (rst)
    (run_q && !start_i) |=> $stable(tmo_q)); // R6
  AST_RUN_SPENT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(run_q && spent_o)); // R8
endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl #(
  parameter int              CP_W    = 2,
  parameter int              NUM_EV  = 2,
  parameter int              EV_ICP  = 0,
  parameter int              EV_SW   = 1,
  parameter logic [CP_W-1:0] CP_WIDE = 2'b11,
  parameter logic [CP_W-1:0] CP_NORM = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [NUM_EV-1:0] hit_i,
  input  logic [NUM_EV-1:0] spent_i,
  output logic [CP_W-1:0]   icp_sel_o,
  output logic              sw1_close_o,
  output logic              sw2_close_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [NUM_EV-1:0] ev_over;
  logic              all_over;

  assign ev_over  = hit_i | spent_i;
  assign all_over = &ev_over;

  always_ff @(posedge clk) begin
    if (rst) begin
      icp_sel_o   <= CP_NORM;
      sw1_close_o <= 1'b0;
      sw2_close_o <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
    end else if (load_i) begin
      icp_sel_o   <= CP_WIDE;
      sw1_close_o <= 1'b1;
      sw2_close_o <= 1'b1;
      busy_o      <= 1'b1;
      done_o      <= 1'b0;
    end else begin
      if (hit_i[EV_ICP]) icp_sel_o <= CP_NORM;
      if (hit_i[EV_SW]) begin
        sw1_close_o <= 1'b0;
        sw2_close_o <= 1'b0;
      end
      if (busy_o && all_over) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  AST_LOAD_WIDE: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (icp_sel_o == CP_WIDE && sw1_close_o && sw2_close_o && busy_o && !done_o)); // R2
  AST_ICP_DROP: assert property (@(posedge clk) disable iff (rst)
    (hit_i[EV_ICP] && !load_i) |=> (icp_sel_o == CP_NORM)); // R3
  AST_SW_DROP: assert property (@(posedge clk) disable iff (rst)
    (hit_i[EV_SW] && !load_i) |=> (!sw1_close_o && !sw2_close_o)); // R4
  AST_SW_PAIR: assert property (@(posedge clk) disable iff (rst)
    sw1_close_o == sw2_close_o); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done_o && !load_i) |=> done_o); // R8
  AST_DONE_NARROW: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (icp_sel_o == CP_NORM && !sw1_close_o)); // R8
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o)); // R8
endmodule

// File: rtl/fastlock_seq.sv
module fastlock_seq
  import fastlock_pkg::*;
#(
  parameter int TMO_W = CNT_W,
  parameter int SEL_W = CP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [TMO_W-1:0] icp_tmo_i,
  input  logic [TMO_W-1:0] sw_tmo_i,
  output logic [SEL_W-1:0] icp_sel_o,
  output logic             sw1_close_o,
  output logic             sw2_close_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [TMO_W-1:0]  tmo_arr [NUM_EV];
  logic [NUM_EV-1:0] hit;
  logic [NUM_EV-1:0] spent;

  assign tmo_arr[EV_ICP] = icp_tmo_i;
  assign tmo_arr[EV_SW]  = sw_tmo_i;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_tmr
    fastlock_timer #(.CNT_W(TMO_W)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .start_i (load_i),
      .tmo_i   (tmo_arr[g]),
      .hit_o   (hit[g]),
      .spent_o (spent[g])
    );
  end

  fastlock_ctrl #(
    .CP_W    (SEL_W),
    .NUM_EV  (NUM_EV),
    .EV_ICP  (EV_ICP),
    .EV_SW   (EV_SW),
    .CP_WIDE (SEL_W'(CP_WIDE)),
    .CP_NORM (SEL_W'(CP_NORM))
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .hit_i       (hit),
    .spent_i     (spent),
    .icp_sel_o   (icp_sel_o),
    .sw1_close_o (sw1_close_o),
    .sw2_close_o (sw2_close_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !done_o && !load_i) |=> (!busy_o && !done_o)); // R10
endmodule

// File: tb/fastlock_seq_tb.sv
`timescale 1ns/1ps
module fastlock_seq_tb;
  localparam logic [1:0] WIDE = 2'b11;
  localparam logic [1:0] NORM = 2'b00;
  localparam int NV = 6;
  localparam int VTI [NV] = '{0, 3, 7, 2, 15, 0};
  localparam int VTS [NV] = '{0, 5, 4, 2, 1, 9};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [9:0] icp_tmo = '0;
  logic [9:0] sw_tmo = '0;
  logic [1:0] icp_sel;
  logic       sw1, sw2, busy, done;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fastlock_seq u_dut (
    .clk(clk), .rst(rst), .load_i(load), .icp_tmo_i(icp_tmo), .sw_tmo_i(sw_tmo),
    .icp_sel_o(icp_sel), .sw1_close_o(sw1), .sw2_close_o(sw2),
    .busy_o(busy), .done_o(done)
  );

  task automatic compare(input string req, input logic [1:0] e_sel, input logic e_sw,
                         input logic e_busy, input logic e_done);
    checks++;
    if (icp_sel !== e_sel || sw1 !== e_sw || sw2 !== e_sw || busy !== e_busy || done !== e_done) begin
      errors++;
      $display("FAIL %s: got sel=%0d sw=%0d%0d busy=%0d done=%0d, expected sel=%0d sw=%0d%0d busy=%0d done=%0d",
               req, icp_sel, sw1, sw2, busy, done, e_sel, e_sw, e_sw, e_busy, e_done);
    end
  endtask

  // n = edges since the load edge; sampled at the negedge after edge n
  task automatic chk_seq(input string req, input int n, input int ti, input int ts);
    int mx;
    logic ed;
    mx = (ti > ts) ? ti : ts;
    ed = (n >= mx + 1);
    compare(req, (n <= ti) ? WIDE : NORM, (n <= ts), !ed, ed);
  endtask

  task automatic chk_idle(input string req);
    compare(req, NORM, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic start_seq(input int ti, input int ts);
    @(negedge clk);
    load = 1'b1;
    icp_tmo = 10'(ti);
    sw_tmo = 10'(ts);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after reset");
    repeat (4) @(negedge clk);
    chk_idle("R10 idle without load");

    // table walk: R2 R3 R4 R5 R8 (zero entries cover R5)
    for (int v = 0; v < NV; v++) begin
      int mx;
      mx = (VTI[v] > VTS[v]) ? VTI[v] : VTS[v];
      start_seq(VTI[v], VTS[v]);
      for (int n = 0; n <= mx + 2; n++) begin
        if (n > 0) @(negedge clk);
        chk_seq((VTI[v] == 0 || VTS[v] == 0) ? "R5 R3 R4 R8" : "R2 R3 R4 R8", n, VTI[v], VTS[v]);
      end
    end
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      compare("R8 done held", NORM, 1'b0, 1'b0, 1'b1);
    end

    // R6: inputs change mid-sequence
    start_seq(5, 8);
    for (int n = 0; n <= 11; n++) begin
      if (n > 0) @(negedge clk);
      if (n == 2) begin
        icp_tmo = 10'd0;
        sw_tmo = 10'd1;
      end
      chk_seq("R6", n, 5, 8);
    end

    // R7: reload during a running sequence
    start_seq(6, 9);
    for (int n = 0; n <= 4; n++) begin
      if (n > 0) @(negedge clk);
      chk_seq("R7 first", n, 6, 9);
    end
    start_seq(3, 2);
    for (int n = 0; n <= 6; n++) begin
      if (n > 0) @(negedge clk);
      chk_seq("R7 restart", n, 3, 2);
    end

    // R9: top of the range
    start_seq(1023, 1000);
    for (int n = 0; n <= 1026; n++) begin
      if (n > 0) @(negedge clk);
      chk_seq("R9", n, 1023, 1000);
    end

    // R1 R10: reset mid-run returns to idle and stays there
    start_seq(4, 4);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R1 mid-run reset");
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk_idle("R10 after reset");
    end

    finish_run();
  end
endmodule